// File: doc/BRIEF.md
# Circular address generator

This block is the address side of a load/store path. It keeps a file of pointer registers. On every access cycle it takes one of them as the base, forms a modifier from a second register or from an immediate, and hands a memory address to the memory stage. Two addressing styles are offered. Pre-modify sends out the modified address and leaves the pointer alone. Post-modify sends out the pointer as it stands and then stores the modified value back into it.

The lowest-numbered pointers can each be tied to a circular buffer, described by its own start address and length. When the length is non-zero, a modified value that runs past the end of the buffer, or drops below its start, is folded back inside by one buffer length. The start address needs no alignment. A separate write port loads pointers, buffer starts and buffer lengths. A combinational read port returns any pointer.

The unit has no pipeline. An access presented in one cycle yields its address on the output register and its pointer update at the same clock edge.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every pointer, buffer start and buffer length is zero, `addr_valid` is low and `addr_out` is zero.
- R2: A post-modify access (`op_post`=1) emits the pointer's value before the access, and the pointer then holds the modified value.
- R3: A pre-modify access (`op_post`=0) emits the modified value, and the pointer keeps its value.
- R4: `addr_valid` and `addr_out` reflect an access at the first clock edge after it is presented. `addr_valid` is low after a cycle with no access. `rd_data` shows pointer `rd_idx` combinationally, including the result of an update at that edge.
- R5: `op_mod_src` picks the modifier. Code 0 selects pointer `op_mod_idx`. Code 1 selects the low 8 bits of `op_imm`, sign-extended. Code 2 selects all of `op_imm`. Code 3 selects zero.
- R6: For pointer k < 4 with buffer start B and non-zero length L, a modified value at or above B+L has L subtracted, and one below B has L added. This applies to the pre-modify address and to the post-modify update alike.
- R7: With a length of zero, the modified value is the plain 32-bit two's-complement sum of pointer and modifier.
- R8: Only pointers 0 to 3 have a buffer start and length. Writes of start or length with an index of 4 or more change nothing.
- R9: If an explicit pointer write and a post-modify update target the same pointer in one cycle, the written data is kept.
- R10: `wr_target` selects the destination at the clock edge while `wr_en` is high. Code 0 selects the pointer, code 1 the buffer start, code 2 the buffer length, and code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An access is requested this cycle |
| op_post | input | 1 | 1 selects post-modify, 0 selects pre-modify |
| op_base_idx | input | 5 | Pointer used as base |
| op_mod_src | input | 2 | Modifier source code (R5) |
| op_mod_idx | input | 5 | Pointer used as modifier when the source code is 0 |
| op_imm | input | 32 | Immediate modifier |
| wr_en | input | 1 | Write port enable |
| wr_target | input | 2 | Write destination code (R10) |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Pointer to read back |
| rd_data | output | 32 | Value of pointer `rd_idx` |
| addr_valid | output | 1 | `addr_out` holds the address of the previous cycle's access |
| addr_out | output | 32 | Memory address |

## Verification
The bench lands a modified value exactly on the buffer end and expects it to fold to the start. A design that compares with "greater than" would leave the pointer one buffer length out of range. Negative short immediates drive the pointer below the buffer start and also test the linear path. Missing sign extension shows up there as a jump of about 256 bytes forward instead of backwards. Further tests show that a pre-modify access that wraps still leaves its pointer untouched, and that a length written to a pointer above the circular range cannot cause a fold. A colliding pointer write and post-modify update must leave the written data, not the updated pointer.

// File: rtl/cag_pkg.sv
package cag_pkg;
   typedef enum logic [1:0] {
      MSRC_REG   = 2'd0,
      MSRC_SHORT = 2'd1,
      MSRC_LONG  = 2'd2,
      MSRC_ZERO  = 2'd3
   } msrc_e;

   typedef enum logic [1:0] {
      WT_PTR   = 2'd0,
      WT_CBASE = 2'd1,
      WT_CLEN  = 2'd2,
      WT_NONE  = 2'd3
   } wtgt_e;
endpackage

// File: rtl/cag_regfile.sv
module cag_regfile
   import cag_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_REGS = 32,
   parameter int NUM_CIRC = 4,
   parameter int IDX_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [IDX_W-1:0]  rc_idx,
   output logic [ADDR_W-1:0] ra_val,
   output logic [ADDR_W-1:0] rb_val,
   output logic [ADDR_W-1:0] rc_val,
   output logic              circ_hit,
   output logic [ADDR_W-1:0] circ_base,
   output logic [ADDR_W-1:0] circ_len,
   input  logic              upd_en,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [ADDR_W-1:0] upd_val,
   input  logic              wr_en,
   input  logic [1:0]        wr_tgt,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data
);
   wtgt_e wt;
   logic  wr_ptr;
   logic [ADDR_W-1:0] ptr_q [NUM_REGS];

   assign wt     = wtgt_e'(wr_tgt);
   assign wr_ptr = wr_en && (wt == WT_PTR);

   // explicit write has priority over the post-modify update
   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_REGS; i++) begin
         if (!rst_n)
            ptr_q[i] <= '0;
         else if (wr_ptr && wr_idx == IDX_W'(i))
            ptr_q[i] <= wr_data;
         else if (upd_en && upd_idx == IDX_W'(i))
            ptr_q[i] <= upd_val;
      end
   end

   assign ra_val = ptr_q[ra_idx];
   assign rb_val = ptr_q[rb_idx];
   assign rc_val = ptr_q[rc_idx];

   generate
      if (NUM_CIRC == 0) begin : g_no_circ
         assign circ_hit  = 1'b0;
         assign circ_base = '0;
         assign circ_len  = '0;
      end else begin : g_circ
         localparam int CIDX_W = (NUM_CIRC > 1) ? $clog2(NUM_CIRC) : 1;
         logic [ADDR_W-1:0] cbase_q [NUM_CIRC];
         logic [ADDR_W-1:0] clen_q  [NUM_CIRC];
         logic [CIDX_W-1:0] cidx;

         always_ff @(posedge clk) begin
            for (int c = 0; c < NUM_CIRC; c++) begin
               if (!rst_n) begin
                  cbase_q[c] <= '0;
                  clen_q[c]  <= '0;
               end else if (wr_en && wr_idx == IDX_W'(c)) begin
                  if (wt == WT_CBASE) cbase_q[c] <= wr_data;
                  if (wt == WT_CLEN)  clen_q[c]  <= wr_data;
               end
            end
         end

         assign cidx      = ra_idx[CIDX_W-1:0];
         assign circ_hit  = (ra_idx < IDX_W'(NUM_CIRC));
         assign circ_base = circ_hit ? cbase_q[cidx] : '0;
         assign circ_len  = circ_hit ? clen_q[cidx]  : '0;
      end
   endgenerate

   // R9: the explicitly written data survives a colliding update
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr && upd_en && wr_idx == upd_idx) |=> ptr_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/cag_modsel.sv
module cag_modsel
   import cag_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int SHORT_W = 8
) (
   input  logic [1:0]        src,
   input  logic [ADDR_W-1:0] reg_val,
   input  logic [ADDR_W-1:0] imm,
   output logic [ADDR_W-1:0] mod_val
);
   generate
      if (SHORT_W < 1 || SHORT_W >= ADDR_W) begin : g_bad_short
         $error("short immediate width must lie between 1 and ADDR_W-1");
      end
   endgenerate

   always_comb begin
      case (msrc_e'(src))
         MSRC_REG:   mod_val = reg_val;
         MSRC_SHORT: mod_val = {{(ADDR_W-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
         MSRC_LONG:  mod_val = imm;
         default:    mod_val = '0;
      endcase
   end
endmodule

// File: rtl/cag_wrap.sv
module cag_wrap #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ptr_i,
   input  logic [ADDR_W-1:0] mod_i,
   input  logic              circ_en_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] len_i,
   output logic [ADDR_W-1:0] res_o
);
   localparam int EW = ADDR_W + 2;

   logic signed [EW-1:0] sum_x, lo_x, hi_x, len_x, mod_x, ptr_x, adj;

   assign ptr_x = $signed({2'b00, ptr_i});
   assign mod_x = $signed({{2{mod_i[ADDR_W-1]}}, mod_i});
   assign lo_x  = $signed({2'b00, base_i});
   assign len_x = $signed({2'b00, len_i});
   assign hi_x  = lo_x + len_x;
   assign sum_x = ptr_x + mod_x;

   always_comb begin
      adj = sum_x;
      if (circ_en_i) begin
         if (sum_x >= hi_x)      adj = sum_x - len_x;
         else if (sum_x < lo_x)  adj = sum_x + len_x;
      end
   end

   assign res_o = adj[ADDR_W-1:0];

   // R6: a pointer inside its buffer, moved by at most one length, stays inside
   a_r6_stays_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      (circ_en_i && hi_x[EW-1:ADDR_W] == 2'b00 && ptr_x >= lo_x && ptr_x < hi_x &&
       ((mod_x < 0) ? -mod_x : mod_x) <= len_x)
      |-> (adj >= lo_x && adj < hi_x));
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
   import cag_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGS    = 32,
   parameter int NUM_CIRC    = 4,
   parameter int SHORT_IMM_W = 8,
   localparam int IDX_W      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_post,
   input  logic [IDX_W-1:0]  op_base_idx,
   input  logic [1:0]        op_mod_src,
   input  logic [IDX_W-1:0]  op_mod_idx,
   input  logic [ADDR_W-1:0] op_imm,
   input  logic              wr_en,
   input  logic [1:0]        wr_target,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr_out
);
   generate
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("NUM_REGS must be at least 2");
      end
      if (NUM_CIRC < 0 || NUM_CIRC > NUM_REGS) begin : g_bad_circ
         $error("NUM_CIRC must lie between 0 and NUM_REGS");
      end
   endgenerate

   logic [ADDR_W-1:0] base_val, modreg_val, mod_val, circ_base, circ_len, mod_res, emit;
   logic              circ_hit, circ_en, upd_en;

   assign upd_en = op_valid && op_post;

   cag_regfile #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NUM_CIRC(NUM_CIRC), .IDX_W(IDX_W)
   ) i_rf (
      .clk(clk), .rst_n(rst_n),
      .ra_idx(op_base_idx), .rb_idx(op_mod_idx), .rc_idx(rd_idx),
      .ra_val(base_val), .rb_val(modreg_val), .rc_val(rd_data),
      .circ_hit(circ_hit), .circ_base(circ_base), .circ_len(circ_len),
      .upd_en(upd_en), .upd_idx(op_base_idx), .upd_val(mod_res),
      .wr_en(wr_en), .wr_tgt(wr_target), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   cag_modsel #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_IMM_W)) i_msel (
      .src(op_mod_src), .reg_val(modreg_val), .imm(op_imm), .mod_val(mod_val)
   );

   assign circ_en = circ_hit && (circ_len != '0);

   cag_wrap #(.ADDR_W(ADDR_W)) i_wrap (
      .clk(clk), .rst_n(rst_n),
      .ptr_i(base_val), .mod_i(mod_val), .circ_en_i(circ_en),
      .base_i(circ_base), .len_i(circ_len), .res_o(mod_res)
   );

   assign emit = op_post ? base_val : mod_res;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_valid <= 1'b0;
         addr_out   <= '0;
      end else begin
         addr_valid <= op_valid;
         if (op_valid) addr_out <= emit;
      end
   end

   // R4: the output strobe follows the request by exactly one edge
   a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> addr_valid);
   a_r4_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !addr_valid);
   // R2: post-modify sends out the pointer as read before the update
   a_r2_post_emits_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_post) |=> addr_out == $past(base_val));
   // R3: pre-modify leaves the pointer as it was
   a_r3_pre_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_post &&
       !(wr_en && wr_target == 2'd0 && wr_idx == op_base_idx))
      |=> i_rf.ptr_q[$past(op_base_idx)] == $past(base_val));
endmodule

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid, op_post;
   logic [4:0]  op_base_idx, op_mod_idx, wr_idx, rd_idx;
   logic [1:0]  op_mod_src, wr_target;
   logic [31:0] op_imm, wr_data, rd_data, addr_out;
   logic        wr_en, addr_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   circ_addr_gen i_circ_addr_gen (
      .clk(clk), .rst_n(rst_n),
      .op_valid(op_valid), .op_post(op_post), .op_base_idx(op_base_idx),
      .op_mod_src(op_mod_src), .op_mod_idx(op_mod_idx), .op_imm(op_imm),
      .wr_en(wr_en), .wr_target(wr_target), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .addr_valid(addr_valid), .addr_out(addr_out)
   );

   typedef struct packed {
      logic        post;
      logic [4:0]  b;
      logic [1:0]  s;
      logic [4:0]  m;
      logic [31:0] imm;
      logic [31:0] ea;   // expected address
      logic [31:0] ep;   // expected pointer afterwards
   } vec_t;

   // buffer 0: start 0x100, length 0x10; r1 = 0x2000, r4 = 0x8000, r5 = 4
   localparam vec_t VT [11] = '{
      '{1'b1, 5'd0, 2'd1, 5'd0, 32'h04,        32'h100,  32'h104},  // R2 R5 short imm
      '{1'b1, 5'd0, 2'd0, 5'd5, 32'h0,         32'h104,  32'h108},  // R5 register modifier
      '{1'b0, 5'd0, 2'd2, 5'd0, 32'h4,         32'h10C,  32'h108},  // R3 pre, long imm
      '{1'b1, 5'd0, 2'd2, 5'd0, 32'h8,         32'h108,  32'h100},  // R6 lands on end
      '{1'b1, 5'd0, 2'd1, 5'd0, 32'hFC,        32'h100,  32'h10C},  // R6 below start
      '{1'b0, 5'd0, 2'd1, 5'd0, 32'h08,        32'h104,  32'h10C},  // R6 R3 pre wraps
      '{1'b1, 5'd1, 2'd1, 5'd0, 32'h80,        32'h2000, 32'h1F80}, // R7 negative short
      '{1'b1, 5'd1, 2'd2, 5'd0, 32'h100,       32'h1F80, 32'h2080}, // R7 linear
      '{1'b0, 5'd4, 2'd0, 5'd1, 32'h0,         32'hA080, 32'h8000}, // R3 R5 reg modifier
      '{1'b1, 5'd4, 2'd1, 5'd0, 32'h7F,        32'h8000, 32'h807F}, // R5 max short imm
      '{1'b1, 5'd1, 2'd2, 5'd0, 32'hFFFFFF00,  32'h2080, 32'h1F80}  // R7 negative long
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic ov, input logic post, input logic [4:0] b,
                      input logic [1:0] s, input logic [4:0] m, input logic [31:0] imm,
                      input logic we, input logic [1:0] wt, input logic [4:0] wi,
                      input logic [31:0] wd, input logic [4:0] ri);
      @(negedge clk);
      op_valid = ov; op_post = post; op_base_idx = b; op_mod_src = s;
      op_mod_idx = m; op_imm = imm;
      wr_en = we; wr_target = wt; wr_idx = wi; wr_data = wd; rd_idx = ri;
      @(negedge clk);
      op_valid = 1'b0; wr_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] wt, input logic [4:0] wi, input logic [31:0] wd);
      cyc(1'b0, 1'b0, 5'd0, 2'd0, 5'd0, 32'h0, 1'b1, wt, wi, wd, wi);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R4 watchdog expired actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; op_valid = 1'b0; op_post = 1'b0; op_base_idx = '0;
      op_mod_src = '0; op_mod_idx = '0; op_imm = '0; wr_en = 1'b0;
      wr_target = '0; wr_idx = '0; wr_data = '0; rd_idx = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 addr_valid after reset", {31'b0, addr_valid}, 32'h0);
      chk("R1 addr_out after reset", addr_out, 32'h0);
      rd_idx = 5'd0;
      #1 chk("R1 pointer 0 after reset", rd_data, 32'h0);
      rst_n = 1'b1;
      // R1: buffer length is zero after reset, so pointer 0 is linear
      cyc(1'b1, 1'b1, 5'd0, 2'd2, 5'd0, 32'h20, 1'b0, 2'd0, 5'd0, 32'h0, 5'd0);
      chk("R1 zero length after reset means linear", rd_data, 32'h20);

      // R10 set-up through the write port
      wr(2'd0, 5'd0, 32'h100);
      chk("R10 pointer write", rd_data, 32'h100);
      wr(2'd1, 5'd0, 32'h100);
      wr(2'd2, 5'd0, 32'h10);
      wr(2'd0, 5'd1, 32'h2000);
      wr(2'd0, 5'd4, 32'h8000);
      wr(2'd0, 5'd5, 32'h4);
      chk("R10 pointer write r5", rd_data, 32'h4);

      // table walk: R2 R3 R5 R6 R7
      for (int i = 0; i < 11; i++) begin
         cyc(1'b1, VT[i].post, VT[i].b, VT[i].s, VT[i].m, VT[i].imm,
             1'b0, 2'd0, 5'd0, 32'h0, VT[i].b);
         chk($sformatf("R4 table %0d addr_valid", i), {31'b0, addr_valid}, 32'h1);
         chk($sformatf("R2_R3_R6_R7 table %0d address", i), addr_out, VT[i].ea);
         chk($sformatf("R2_R3_R6_R7 table %0d pointer", i), rd_data, VT[i].ep);
      end

      // R4: an idle cycle clears addr_valid
      @(negedge clk);
      chk("R4 idle clears addr_valid", {31'b0, addr_valid}, 32'h0);

      // R8: start and length for pointer 4 are ignored, so no fold
      wr(2'd1, 5'd4, 32'h8000);
      wr(2'd2, 5'd4, 32'h10);
      cyc(1'b1, 1'b1, 5'd4, 2'd1, 5'd0, 32'h10, 1'b0, 2'd0, 5'd0, 32'h0, 5'd4);
      chk("R8 pointer 4 address", addr_out, 32'h807F);
      chk("R8 pointer 4 stays linear", rd_data, 32'h808F);

      // R10: target code 3 writes nothing
      wr(2'd3, 5'd5, 32'hDEAD);
      chk("R10 target 3 ignored", rd_data, 32'h4);

      // R5: source code 3 adds zero
      cyc(1'b1, 1'b0, 5'd5, 2'd3, 5'd7, 32'h1234, 1'b0, 2'd0, 5'd0, 32'h0, 5'd5);
      chk("R5 zero modifier address", addr_out, 32'h4);

      // R9: explicit write wins over post-modify update
      cyc(1'b1, 1'b1, 5'd5, 2'd1, 5'd0, 32'h01, 1'b1, 2'd0, 5'd5, 32'h55, 5'd5);
      chk("R9 address still emitted", addr_out, 32'h4);
      chk("R9 written data kept", rd_data, 32'h55);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule